// File: doc/BRIEF.md
# Dimming Curve Modulator with Standby

This block takes a stream of normalized dimming codes and maps each one to a modulated output code. The full-scale code `FS` stands for 100%. A programmable input window sets the useful part of the input range. Codes at or below the window's lower edge give a configurable non-zero minimum output. Codes at or above its upper edge give the full-scale output. Between the edges, the output rises from the minimum to full scale along a linear, square or cube law. Percentages in the configuration are turned into codes as `floor(FS * permille / 1000)`.

Every valid input also updates a standby decision. The decision uses a pair of thresholds with hysteresis, and it travels down the pipeline so that the standby flag changes together with the output code of the same sample. The configuration is captured by a one-cycle load strobe. The reciprocal of the window span is computed at that moment, so the per-sample datapath needs only multipliers. Detection of the analog or duty-cycle input, and any use of the output code further downstream, belong to other blocks.

Top module: `dimc_modulator`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `out_code` are 0 and `standby` is 1. The configuration then in effect is: lower edge 10%, upper edge 90%, floor 1%, linear curve, standby pair 3%/5%.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, three rising clock edges later. Results leave in the order the samples arrived.
- R3: An input code at or below the lower window edge gives `out_code` equal to the floor. The `cfg_lo_sel` field selects the lower edge: 0 means 0%, 1 means 10%. The `cfg_floor_sel` field selects the floor: 0 → 10%, 1 → 7.5%, 2 → 5%, 3 → 2%, 4 to 7 → 1%.
- R4: An input code at or above the upper window edge gives `out_code` equal to `FS`. The `cfg_hi_sel` field selects the upper edge: 0 → 100%, 1 → 90%, 2 → 85%, 3 → 80%.
- R5: In linear mode (`cfg_curve_sel` 0 or 3), an input x inside the window gives `out = fl + ((u*(FS-fl)) >> FRAC)`. Here `u = (x-lo)*floor(2^FRAC/(hi-lo))`, `lo` and `hi` are the window edges and `fl` is the floor.
- R6: When `cfg_curve_sel` is 1, u is replaced by `(u*u)>>FRAC`. When it is 2, u is replaced by `(((u*u)>>FRAC)*u)>>FRAC`. In both cases u is first set to exactly `2^FRAC` at or above the upper edge.
- R7: Standby is entered when an input is strictly below the entry threshold. It is left when an input is strictly above the exit threshold. An input between the two thresholds, inclusive, leaves the flag unchanged. The `cfg_stby_sel` field selects the pair: 0 → 2%/3%, 1 → 3%/5%, 2 → 6%/8%.
- R8: When `cfg_stby_sel` is 3, standby is disabled, and the flag reports 0 for every sample accepted under that setting.
- R9: `out_code` and `standby` change only in cycles where `out_valid` is high.
- R10: A configuration presented with `cfg_load` high is captured at that clock edge. It applies to every sample accepted after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for the configuration fields |
| cfg_lo_sel | input | 1 | Lower window edge select |
| cfg_hi_sel | input | 2 | Upper window edge select |
| cfg_floor_sel | input | 3 | Output floor select |
| cfg_curve_sel | input | 2 | Curve law select |
| cfg_stby_sel | input | 2 | Standby threshold pair select |
| in_valid | input | 1 | Input sample strobe |
| in_code | input | W | Input dimming code, 0 to FS |
| out_valid | output | 1 | Output sample strobe |
| out_code | output | W | Modulated output code |
| standby | output | 1 | Standby flag aligned with out_code |

## Verification
The bench builds the block with `FS = 200`, so a code step is 0.5%. With that setting, every window edge, floor and standby threshold lands on an exact integer code, and all 201 input codes can be swept for each configuration. It loops over every lower edge, upper edge, floor value and curve law, rotates through the four standby settings, and alternates rising and falling sweeps. Both hysteresis directions and both clamps are therefore hit under each window. `FRAC = 16` and `MAX_POW = 3` keep the square and cube paths present, so their truncation steps are checked against arithmetic done in the bench.

// File: rtl/dimc_pkg.sv
package dimc_pkg;

   localparam int unsigned PIPE_LAT = 3;

   typedef enum logic [1:0] {
      CRV_LIN = 2'd0,
      CRV_SQR = 2'd1,
      CRV_CUB = 2'd2,
      CRV_ALT = 2'd3
   } curve_e;

   function automatic int unsigned pm_to_code(int unsigned fs, int unsigned pm);
      return (fs * pm) / 1000;
   endfunction

   function automatic int unsigned win_lo_pm(logic sel);
      return sel ? 100 : 0;
   endfunction

   function automatic int unsigned win_hi_pm(logic [1:0] sel);
      case (sel)
         2'd0:    return 1000;
         2'd1:    return 900;
         2'd2:    return 850;
         default: return 800;
      endcase
   endfunction

   function automatic int unsigned floor_pm(logic [2:0] sel);
      case (sel)
         3'd0:    return 100;
         3'd1:    return 75;
         3'd2:    return 50;
         3'd3:    return 20;
         default: return 10;
      endcase
   endfunction

   function automatic int unsigned stby_in_pm(logic [1:0] sel);
      case (sel)
         2'd0:    return 20;
         2'd1:    return 30;
         2'd2:    return 60;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned stby_out_pm(logic [1:0] sel);
      case (sel)
         2'd0:    return 30;
         2'd1:    return 50;
         2'd2:    return 80;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/dimc_cfg.sv
module dimc_cfg
   import dimc_pkg::*;
#(
   parameter int unsigned FS   = 1000,
   parameter int unsigned FRAC = 16,
   parameter int unsigned W    = 10,
   parameter int unsigned UW   = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          lo_sel,
   input  logic [1:0]    hi_sel,
   input  logic [2:0]    floor_sel,
   input  logic [1:0]    curve_sel,
   input  logic [1:0]    stby_sel,
   output logic [W-1:0]  lo_q,
   output logic [W-1:0]  hi_q,
   output logic [W-1:0]  floor_q,
   output logic [W-1:0]  rng_q,
   output logic [UW-1:0] recip_q,
   output curve_e        curve_q,
   output logic [W-1:0]  enter_q,
   output logic [W-1:0]  exit_q,
   output logic          off_q
);

   localparam logic [W-1:0]  DEF_LO    = W'(FS * 100 / 1000);
   localparam logic [W-1:0]  DEF_HI    = W'(FS * 900 / 1000);
   localparam logic [W-1:0]  DEF_FL    = W'(FS * 10 / 1000);
   localparam logic [W-1:0]  DEF_EN    = W'(FS * 30 / 1000);
   localparam logic [W-1:0]  DEF_EX    = W'(FS * 50 / 1000);
   localparam logic [UW-1:0] ONE       = UW'(1) << FRAC;
   localparam logic [UW-1:0] DEF_RECIP = ONE / UW'(DEF_HI - DEF_LO);

   logic [W-1:0]  lo_d, hi_d, fl_d, en_d, ex_d;
   logic [UW-1:0] recip_d;

   // The reciprocal of the window span is formed only when a load happens.
   always_comb begin
      lo_d    = W'(pm_to_code(FS, win_lo_pm(lo_sel)));
      hi_d    = W'(pm_to_code(FS, win_hi_pm(hi_sel)));
      fl_d    = W'(pm_to_code(FS, floor_pm(floor_sel)));
      en_d    = W'(pm_to_code(FS, stby_in_pm(stby_sel)));
      ex_d    = W'(pm_to_code(FS, stby_out_pm(stby_sel)));
      recip_d = ONE / UW'(hi_d - lo_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= DEF_LO;
         hi_q    <= DEF_HI;
         floor_q <= DEF_FL;
         rng_q   <= W'(FS) - DEF_FL;
         recip_q <= DEF_RECIP;
         curve_q <= CRV_LIN;
         enter_q <= DEF_EN;
         exit_q  <= DEF_EX;
         off_q   <= 1'b0;
      end else if (load) begin
         lo_q    <= lo_d;
         hi_q    <= hi_d;
         floor_q <= fl_d;
         rng_q   <= W'(FS) - fl_d;
         recip_q <= recip_d;
         curve_q <= curve_e'(curve_sel);
         enter_q <= en_d;
         exit_q  <= ex_d;
         off_q   <= (stby_sel == 2'd3);
      end
   end

endmodule

// File: rtl/dimc_curve.sv
module dimc_curve
   import dimc_pkg::*;
#(
   parameter int unsigned FRAC    = 16,
   parameter int unsigned W       = 10,
   parameter int unsigned UW      = 17,
   parameter int unsigned MAX_POW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [W-1:0]  in_code,
   input  logic [W-1:0]  lo,
   input  logic [W-1:0]  hi,
   input  logic [W-1:0]  floor_lvl,
   input  logic [W-1:0]  rng,
   input  logic [UW-1:0] recip,
   input  curve_e        curve,
   output logic [2:0]    stage_v,
   output logic [W-1:0]  out_code
);

   localparam logic [UW-1:0] ONE = UW'(1) << FRAC;

   // Stage 1: clamp into the window, then take the distance from its lower edge.
   logic [W-1:0] xc, d1;
   logic         v1, full1;

   always_comb xc = (in_code < lo) ? lo : ((in_code > hi) ? hi : in_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         d1    <= '0;
         full1 <= 1'b0;
      end else begin
         v1 <= in_valid;
         if (in_valid) begin
            d1    <= xc - lo;
            full1 <= (in_code >= hi);
         end
      end
   end

   // Stage 2: normalized position, exactly ONE at or above the upper edge.
   logic [W+UW-1:0] frac_w;
   logic [UW-1:0]   u2;
   logic            v2;

   assign frac_w = {{UW{1'b0}}, d1} * {{W{1'b0}}, recip};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2 <= 1'b0;
         u2 <= '0;
      end else begin
         v2 <= v1;
         if (v1) u2 <= full1 ? ONE : UW'(frac_w);
      end
   end

   // Stage 3: power law, then scale into [floor, FS].
   logic [UW-1:0] upow;

   generate
      if (MAX_POW >= 2) begin : g_pow
         logic [2*UW-1:0] sq_w;
         logic [UW-1:0]   sq_n;
         assign sq_w = {{UW{1'b0}}, u2} * {{UW{1'b0}}, u2};
         assign sq_n = UW'(sq_w >> FRAC);
         if (MAX_POW >= 3) begin : g_cube
            logic [2*UW-1:0] cb_w;
            assign cb_w = {{UW{1'b0}}, sq_n} * {{UW{1'b0}}, u2};
            always_comb begin
               case (curve)
                  CRV_SQR: upow = sq_n;
                  CRV_CUB: upow = UW'(cb_w >> FRAC);
                  default: upow = u2;
               endcase
            end
         end else begin : g_sq_only
            always_comb upow = (curve == CRV_SQR || curve == CRV_CUB) ? sq_n : u2;
         end
      end else begin : g_lin_only
         always_comb upow = u2;
      end
   endgenerate

   logic [UW+W-1:0] prod_w;
   logic            v3;

   assign prod_w = {{W{1'b0}}, upow} * {{UW{1'b0}}, rng};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v3       <= 1'b0;
         out_code <= '0;
      end else begin
         v3 <= v2;
         if (v2) out_code <= floor_lvl + W'(prod_w >> FRAC);
      end
   end

   assign stage_v = {v3, v2, v1};

   // R6: the normalized position never exceeds unity.
   a_r6_unit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      v2 |-> u2 <= ONE);

endmodule

// File: rtl/dimc_stby.sv
module dimc_stby
   import dimc_pkg::*;
#(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_code,
   input  logic [W-1:0] enter_lvl,
   input  logic [W-1:0] exit_lvl,
   input  logic         off,
   input  logic [1:0]   stage_v,
   output logic         standby
);

   logic st, st_nx, d2, d3;

   always_comb begin
      st_nx = st;
      if (off)                          st_nx = 1'b0;
      else if (st && in_code > exit_lvl)  st_nx = 1'b0;
      else if (!st && in_code < enter_lvl) st_nx = 1'b1;
   end

   // The decision is made in stage 1 and then rides along with its sample.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= 1'b1;
         d2 <= 1'b1;
         d3 <= 1'b1;
      end else begin
         if (in_valid)   st <= st_nx;
         if (stage_v[0]) d2 <= st;
         if (stage_v[1]) d3 <= d2;
      end
   end

   assign standby = d3;

   a_r7_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !off && in_code >= enter_lvl && in_code <= exit_lvl) |=> st == $past(st));

   a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && off) |=> !st);

endmodule

// File: rtl/dimc_modulator.sv
module dimc_modulator
   import dimc_pkg::*;
#(
   parameter int unsigned FS      = 1000,
   parameter int unsigned FRAC    = 16,
   parameter int unsigned MAX_POW = 3,
   localparam int unsigned W      = $clog2(FS + 1),
   localparam int unsigned UW     = FRAC + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_load,
   input  logic         cfg_lo_sel,
   input  logic [1:0]   cfg_hi_sel,
   input  logic [2:0]   cfg_floor_sel,
   input  logic [1:0]   cfg_curve_sel,
   input  logic [1:0]   cfg_stby_sel,
   input  logic         in_valid,
   input  logic [W-1:0] in_code,
   output logic         out_valid,
   output logic [W-1:0] out_code,
   output logic         standby
);

   generate
      if (FS < 100)                    begin : g_bad_fs   $error("FS must be at least 100"); end
      if (FRAC < 8 || FRAC > 30)       begin : g_bad_frac $error("FRAC must be 8 to 30"); end
      if ((FS >> FRAC) != 0)           begin : g_bad_res  $error("FS must be below 2**FRAC"); end
      if (MAX_POW < 1 || MAX_POW > 3)  begin : g_bad_pow  $error("MAX_POW must be 1 to 3"); end
   endgenerate

   logic [W-1:0]  lo_q, hi_q, floor_q, rng_q, enter_q, exit_q;
   logic [UW-1:0] recip_q;
   curve_e        curve_q;
   logic          off_q;
   logic [2:0]    stage_v;

   dimc_cfg #(.FS(FS), .FRAC(FRAC), .W(W), .UW(UW)) i_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load),
      .lo_sel(cfg_lo_sel), .hi_sel(cfg_hi_sel), .floor_sel(cfg_floor_sel),
      .curve_sel(cfg_curve_sel), .stby_sel(cfg_stby_sel),
      .lo_q(lo_q), .hi_q(hi_q), .floor_q(floor_q), .rng_q(rng_q),
      .recip_q(recip_q), .curve_q(curve_q), .enter_q(enter_q),
      .exit_q(exit_q), .off_q(off_q)
   );

   dimc_curve #(.FRAC(FRAC), .W(W), .UW(UW), .MAX_POW(MAX_POW)) i_curve (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
      .lo(lo_q), .hi(hi_q), .floor_lvl(floor_q), .rng(rng_q),
      .recip(recip_q), .curve(curve_q), .stage_v(stage_v), .out_code(out_code)
   );

   dimc_stby #(.W(W)) i_stby (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
      .enter_lvl(enter_q), .exit_lvl(exit_q), .off(off_q),
      .stage_v(stage_v[1:0]), .standby(standby)
   );

   assign out_valid = stage_v[2];

   // Cycles since reset, saturating, so the latency check never looks before reset.
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> out_valid == $past(in_valid, 3));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_code) && $stable(standby)));

   a_r4_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_code <= W'(FS) && out_code >= W'(FS * 10 / 1000)));

endmodule

// File: tb/test_dimc_modulator.sv
module test_dimc_modulator;
   localparam int FS   = 200;
   localparam int FRAC = 16;
   localparam int W    = $clog2(FS + 1);

   logic         clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, cfg_lo_sel = 1'b0;
   logic [1:0]   cfg_hi_sel = '0, cfg_curve_sel = '0, cfg_stby_sel = '0;
   logic [2:0]   cfg_floor_sel = '0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_code = '0;
   logic         out_valid, standby;
   logic [W-1:0] out_code;

   dimc_modulator #(.FS(FS), .FRAC(FRAC), .MAX_POW(3)) i_dimc_modulator (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lo_sel(cfg_lo_sel),
      .cfg_hi_sel(cfg_hi_sel), .cfg_floor_sel(cfg_floor_sel),
      .cfg_curve_sel(cfg_curve_sel), .cfg_stby_sel(cfg_stby_sel),
      .in_valid(in_valid), .in_code(in_code), .out_valid(out_valid),
      .out_code(out_code), .standby(standby)
   );

   always #10 clk = ~clk;

   int     checks = 0, bad = 0;
   longint cyc = 0;
   bit     done = 1'b0;
   always @(posedge clk) cyc <= cyc + 1;

   // Model configuration (R1 defaults)
   int m_lo = 1, m_hi = 1, m_fl = 4, m_cv = 0, m_sb = 1;
   bit m_st = 1'b1;
   int     q_x[$];
   longint q_c[$];

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint pc(longint pm); return (FS * pm) / 1000; endfunction
   function automatic longint lo_c(); return pc(m_lo != 0 ? 100 : 0); endfunction
   function automatic longint hi_c();
      case (m_hi) 0: return pc(1000); 1: return pc(900); 2: return pc(850); default: return pc(800); endcase
   endfunction
   function automatic longint fl_c();
      case (m_fl) 0: return pc(100); 1: return pc(75); 2: return pc(50); 3: return pc(20); default: return pc(10); endcase
   endfunction
   function automatic longint en_c();
      case (m_sb) 0: return pc(20); 1: return pc(30); 2: return pc(60); default: return 0; endcase
   endfunction
   function automatic longint ex_c();
      case (m_sb) 0: return pc(30); 1: return pc(50); 2: return pc(80); default: return 0; endcase
   endfunction

   function automatic longint model_code(longint x);
      longint lo = lo_c(), hi = hi_c(), fl = fl_c();
      longint one = longint'(1) << FRAC;
      longint rc = one / (hi - lo);
      longint u, uk;
      if (x >= hi)      u = one;
      else if (x <= lo) u = 0;
      else              u = (x - lo) * rc;
      if (m_cv == 1)      uk = (u * u) >> FRAC;
      else if (m_cv == 2) uk = (((u * u) >> FRAC) * u) >> FRAC;
      else                uk = u;
      return fl + ((uk * (FS - fl)) >> FRAC);
   endfunction

   // Output monitor: latency, code and standby flag of every result
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_x.size() == 0) chk("R2 unexpected output", 1, 0);
         else begin
            int     x;
            longint c;
            string  tag;
            x = q_x.pop_front();
            c = q_c.pop_front();
            chk("R2 latency", cyc, c);
            if (x <= lo_c())                tag = "R3 low clamp (R10 cfg)";
            else if (x >= hi_c())           tag = "R4 high clamp (R10 cfg)";
            else if (m_cv == 1 || m_cv == 2) tag = "R6 power curve (R10 cfg)";
            else                            tag = "R5 linear curve (R10 cfg)";
            chk(tag, out_code, model_code(x));
            if (m_sb == 3)                 m_st = 1'b0;
            else if (m_st && x > ex_c())   m_st = 1'b0;
            else if (!m_st && x < en_c())  m_st = 1'b1;
            chk(m_sb == 3 ? "R8 standby disabled" : "R7 standby hysteresis", standby, m_st);
         end
      end
   end

   task automatic send(int x);
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_code  = W'(x);
      q_x.push_back(x);
      q_c.push_back(cyc + 3);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b0;
      end
   endtask

   // R10: fields captured on the strobe edge, used by later samples
   task automatic load(int lo, int hi, int fl, int cv, int sb);
      @(posedge clk); #1;
      in_valid = 1'b0;
      cfg_lo_sel = lo[0]; cfg_hi_sel = hi[1:0]; cfg_floor_sel = fl[2:0];
      cfg_curve_sel = cv[1:0]; cfg_stby_sel = sb[1:0]; cfg_load = 1'b1;
      @(posedge clk); #1;
      cfg_load = 1'b0;
      m_lo = lo; m_hi = hi; m_fl = fl; m_cv = cv; m_sb = sb;
   endtask

   initial begin
      #(64'd200000 * 20);
      if (!done) begin
         done = 1'b1;
         bad++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      int cfg_n;
      logic [W-1:0] held;
      logic         held_s;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset out_valid", out_valid, 0);
      chk("R1 reset out_code", out_code, 0);
      chk("R1 reset standby", standby, 1);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset standby", standby, 1);
      chk("R1 after reset out_valid", out_valid, 0);

      // R1 default configuration, standby band from reset
      send(0); send(5); send(8); send(12); send(20); send(60);
      send(100); send(180); send(200); send(30); send(9); send(5);
      idle(6);

      // R9: nothing moves while no result is produced
      @(negedge clk);
      held = out_code; held_s = standby;
      repeat (4) @(negedge clk);
      chk("R9 idle out_valid", out_valid, 0);
      chk("R9 idle out_code", out_code, held);
      chk("R9 idle standby", standby, held_s);

      cfg_n = 0;
      for (int lo = 0; lo < 2; lo++)
         for (int hi = 0; hi < 4; hi++)
            for (int fl = 0; fl < 5; fl++)
               for (int cv = 0; cv < 4; cv++) begin
                  load(lo, hi, fl, cv, cfg_n % 4);
                  for (int i = 0; i <= FS; i++) send((cfg_n % 2 == 0) ? i : FS - i);
                  idle(5);
                  cfg_n++;
               end

      idle(5);
      chk("R2 all results delivered", q_x.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule